// File: doc/BRIEF.md
# DMA Controller Programming Register File

This block is the processor-facing register port of a four-channel DMA engine. While the processor owns the bus, it addresses one of sixteen byte-wide offsets with a 4-bit register select. It writes through a one-cycle write strobe and reads through a one-cycle read strobe. A read and a write to the same offset can reach different registers.

Each channel holds a 16-bit address and a 16-bit transfer count, both in base and current copies, plus a 6-bit mode field. The processor moves these 16-bit values one byte at a time. A single byte-pointer flip-flop, shared by all channels, picks the low or the high byte. The block also holds a command byte, software request bits, channel mask bits and sticky terminal-count flags. Some offsets are pure commands: they clear the byte pointer, perform a master clear, or clear every mask.

The arbiter and the transfer sequencer read every register from flat output buses. They return new current address and count values, terminal-count events and the raw request lines. Read data is registered and appears one cycle after the read strobe.

Top module: `dmaRegFile`

## Requirements
- R1: After reset, all address, count and mode registers, the command byte, the request bits, the terminal-count flags and the read data are zero. All four mask bits are set, and the byte pointer selects the low byte.
- R2: A write to an offset below 8 selects channel offset[2:1]. It selects the address when offset[0]=0 and the count when offset[0]=1. It loads the byte picked by the pointer (low when the pointer is clear) into both the base and the current copy, and then toggles the pointer.
- R3: A read of an offset below 8 returns, in the next cycle, the byte picked by the pointer from the current copy of the selected register, and then toggles the pointer.
- R4: A write to offset 12 returns the byte pointer to the low byte, whatever data is written.
- R5: A write to offset 8 loads the command byte. A read of offset 8 returns {raw request lines[3:0], terminal-count flags[3:0]} in the next cycle and clears the flags.
- R6: A terminal-count event on a channel sets that channel's flag, and the flag stays set until a status read or a master clear. An event in the same cycle as a status read leaves its flag set.
- R7: A write to offset 9 sets request bit data[1:0] when data[2]=1 and clears it when data[2]=0.
- R8: A write to offset 10 sets mask bit data[1:0] when data[2]=1 and clears it when data[2]=0. A write to offset 14 clears all masks. A write to offset 15 loads the masks from data[3:0].
- R9: A write to offset 11 loads data[7:2] into the mode field of channel data[1:0].
- R10: A write to offset 13 clears the command byte, the request bits, the terminal-count flags and the byte pointer, and sets all mask bits. Addresses, counts and modes are kept.
- R11: A sequencer update loads a channel's current address and count. A processor byte write in the same cycle overrides only the byte it targets.
- R12: A read of offsets 9 to 15 returns 0x00 and leaves the pointer unchanged. When read and write strobes coincide, only the write takes effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous active-low reset |
| regAddr | input | 4 | Register offset select |
| wrData | input | 8 | Processor write data |
| wrStrobe | input | 1 | One-cycle write strobe |
| rdStrobe | input | 1 | One-cycle read strobe |
| rdData | output | 8 | Registered read data |
| dreqRaw | input | 4 | Raw channel request lines for status |
| tcPulse | input | 4 | Terminal-count events from the sequencer |
| updEn | input | 4 | Per-channel current-register update enable |
| updAddrFlat | input | 64 | New current addresses, channel c at [16c+15:16c] |
| updCountFlat | input | 64 | New current counts, same packing |
| curAddrFlat | output | 64 | Current addresses |
| curCountFlat | output | 64 | Current counts |
| baseAddrFlat | output | 64 | Base addresses |
| baseCountFlat | output | 64 | Base counts |
| modeFlat | output | 24 | Mode fields, channel c at [6c+5:6c] |
| cmdBits | output | 8 | Command byte |
| reqBits | output | 4 | Software request bits |
| maskBits | output | 4 | Channel mask bits |

## Verification
Every register output changes at the first clock edge after the strobe or update that causes it. Read data, and the pointer move a read makes, show one edge after the read strobe. The bench drives inputs just after a falling edge and lets a behavioural model consume them at the rising edge. It compares all outputs at the next falling edge, so every result is checked in the cycle it becomes due and never earlier. The status-clear and pointer-toggle effects of a read are checked by the reads that follow.

// File: rtl/dmaRegPkg.sv
package dmaRegPkg;
  localparam int CH_NUM = 4;
  localparam int CH_W   = $clog2(CH_NUM);
  localparam int BYTE_W = 8;
  localparam int WORD_W = 2 * BYTE_W;
  localparam int MODE_W = BYTE_W - CH_W;
  localparam int OFF_W  = 4;

  typedef struct packed {
    logic            wrLo;
    logic            wrHi;
    logic            selCount;
    logic [CH_W-1:0] chan;
    logic            ptrToggle;
    logic            ptrClear;
    logic            masterClear;
    logic            cmdWr;
    logic            reqWr;
    logic            maskOne;
    logic            maskNone;
    logic            maskAll;
    logic            modeWr;
    logic            rdPair;
    logic            rdStatus;
    logic            rdZero;
    logic            rdHi;
  } regStrobes_t;
endpackage

// File: rtl/dmaRegCtrl.sv
module dmaRegCtrl
  import dmaRegPkg::*;
(
  input  logic             clk,
  input  logic             rstN,
  input  logic [OFF_W-1:0] regAddr,
  input  logic             wrStrobe,
  input  logic             rdStrobe,
  output regStrobes_t      strobes
);
  logic bytePtr;
  logic wrOp;
  logic rdOp;
  logic pairOff;

  assign wrOp    = wrStrobe;
  assign rdOp    = rdStrobe & ~wrStrobe;
  assign pairOff = ~regAddr[OFF_W-1];

  always_comb begin
    strobes          = '0;
    strobes.chan     = regAddr[CH_W:1];
    strobes.selCount = regAddr[0];
    strobes.rdHi     = bytePtr;
    if (wrOp) begin
      if (pairOff) begin
        strobes.wrLo      = ~bytePtr;
        strobes.wrHi      = bytePtr;
        strobes.ptrToggle = 1'b1;
      end else begin
        unique case (regAddr[OFF_W-2:0])
          3'd0: strobes.cmdWr       = 1'b1;
          3'd1: strobes.reqWr       = 1'b1;
          3'd2: strobes.maskOne     = 1'b1;
          3'd3: strobes.modeWr      = 1'b1;
          3'd4: strobes.ptrClear    = 1'b1;
          3'd5: strobes.masterClear = 1'b1;
          3'd6: strobes.maskNone    = 1'b1;
          default: strobes.maskAll  = 1'b1;
        endcase
      end
    end else if (rdOp) begin
      if (pairOff) begin
        strobes.rdPair    = 1'b1;
        strobes.ptrToggle = 1'b1;
      end else if (regAddr[OFF_W-2:0] == '0) begin
        strobes.rdStatus = 1'b1;
      end else begin
        strobes.rdZero = 1'b1;
      end
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      bytePtr <= 1'b0;
    end else if (strobes.ptrClear || strobes.masterClear) begin
      bytePtr <= 1'b0;
    end else if (strobes.ptrToggle) begin
      bytePtr <= ~bytePtr;
    end
  end
endmodule

// File: rtl/dmaRegData.sv
module dmaRegData
  import dmaRegPkg::*;
(
  input  logic                     clk,
  input  logic                     rstN,
  input  regStrobes_t              strobes,
  input  logic [BYTE_W-1:0]        wrData,
  input  logic [CH_NUM-1:0]        dreqRaw,
  input  logic [CH_NUM-1:0]        tcPulse,
  input  logic [CH_NUM-1:0]        updEn,
  input  logic [CH_NUM*WORD_W-1:0] updAddrFlat,
  input  logic [CH_NUM*WORD_W-1:0] updCountFlat,
  output logic [BYTE_W-1:0]        rdData,
  output logic [CH_NUM*WORD_W-1:0] curAddrFlat,
  output logic [CH_NUM*WORD_W-1:0] curCountFlat,
  output logic [CH_NUM*WORD_W-1:0] baseAddrFlat,
  output logic [CH_NUM*WORD_W-1:0] baseCountFlat,
  output logic [CH_NUM*MODE_W-1:0] modeFlat,
  output logic [BYTE_W-1:0]        cmdBits,
  output logic [CH_NUM-1:0]        reqBits,
  output logic [CH_NUM-1:0]        maskBits
);
  logic [WORD_W-1:0] curAddrArr [CH_NUM];
  logic [WORD_W-1:0] curCntArr  [CH_NUM];
  logic [CH_W-1:0]   dataChan;
  logic [CH_NUM-1:0] tcFlags;
  logic [WORD_W-1:0] rdWord;

  assign dataChan = wrData[CH_W-1:0];

  for (genvar c = 0; c < CH_NUM; c++) begin : g_ch
    logic              chHit;
    logic              loA, hiA, loC, hiC;
    logic [WORD_W-1:0] baseA, curA, baseC, curC;
    logic [MODE_W-1:0] modeR;

    assign chHit = (strobes.chan == CH_W'(c));
    assign loA   = chHit & strobes.wrLo & ~strobes.selCount;
    assign hiA   = chHit & strobes.wrHi & ~strobes.selCount;
    assign loC   = chHit & strobes.wrLo &  strobes.selCount;
    assign hiC   = chHit & strobes.wrHi &  strobes.selCount;

    always_ff @(posedge clk or negedge rstN) begin
      if (!rstN) begin
        baseA <= '0;
        curA  <= '0;
        baseC <= '0;
        curC  <= '0;
      end else begin
        if (updEn[c]) begin
          curA <= updAddrFlat[c*WORD_W +: WORD_W];
          curC <= updCountFlat[c*WORD_W +: WORD_W];
        end
        if (loA) begin
          baseA[BYTE_W-1:0] <= wrData;
          curA[BYTE_W-1:0]  <= wrData;
        end
        if (hiA) begin
          baseA[WORD_W-1:BYTE_W] <= wrData;
          curA[WORD_W-1:BYTE_W]  <= wrData;
        end
        if (loC) begin
          baseC[BYTE_W-1:0] <= wrData;
          curC[BYTE_W-1:0]  <= wrData;
        end
        if (hiC) begin
          baseC[WORD_W-1:BYTE_W] <= wrData;
          curC[WORD_W-1:BYTE_W]  <= wrData;
        end
      end
    end

    always_ff @(posedge clk or negedge rstN) begin
      if (!rstN) begin
        modeR <= '0;
      end else if (strobes.modeWr && dataChan == CH_W'(c)) begin
        modeR <= wrData[BYTE_W-1:CH_W];
      end
    end

    assign curAddrArr[c]                     = curA;
    assign curCntArr[c]                      = curC;
    assign curAddrFlat[c*WORD_W +: WORD_W]   = curA;
    assign curCountFlat[c*WORD_W +: WORD_W]  = curC;
    assign baseAddrFlat[c*WORD_W +: WORD_W]  = baseA;
    assign baseCountFlat[c*WORD_W +: WORD_W] = baseC;
    assign modeFlat[c*MODE_W +: MODE_W]      = modeR;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      cmdBits  <= '0;
      reqBits  <= '0;
      maskBits <= '1;
      tcFlags  <= '0;
    end else if (strobes.masterClear) begin
      cmdBits  <= '0;
      reqBits  <= '0;
      maskBits <= '1;
      tcFlags  <= '0;
    end else begin
      tcFlags <= (strobes.rdStatus ? '0 : tcFlags) | tcPulse;
      if (strobes.cmdWr) cmdBits <= wrData;
      if (strobes.reqWr) reqBits[dataChan] <= wrData[CH_W];
      if (strobes.maskOne) maskBits[dataChan] <= wrData[CH_W];
      else if (strobes.maskNone) maskBits <= '0;
      else if (strobes.maskAll) maskBits <= wrData[CH_NUM-1:0];
    end
  end

  assign rdWord = strobes.selCount ? curCntArr[strobes.chan] : curAddrArr[strobes.chan];

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      rdData <= '0;
    end else if (strobes.rdPair) begin
      rdData <= strobes.rdHi ? rdWord[WORD_W-1:BYTE_W] : rdWord[BYTE_W-1:0];
    end else if (strobes.rdStatus) begin
      rdData <= {dreqRaw, tcFlags};
    end else if (strobes.rdZero) begin
      rdData <= '0;
    end
  end
endmodule

// File: rtl/dmaRegFile.sv
module dmaRegFile
  import dmaRegPkg::*;
(
  input  logic                     clk,
  input  logic                     rstN,
  input  logic [OFF_W-1:0]         regAddr,
  input  logic [BYTE_W-1:0]        wrData,
  input  logic                     wrStrobe,
  input  logic                     rdStrobe,
  output logic [BYTE_W-1:0]        rdData,
  input  logic [CH_NUM-1:0]        dreqRaw,
  input  logic [CH_NUM-1:0]        tcPulse,
  input  logic [CH_NUM-1:0]        updEn,
  input  logic [CH_NUM*WORD_W-1:0] updAddrFlat,
  input  logic [CH_NUM*WORD_W-1:0] updCountFlat,
  output logic [CH_NUM*WORD_W-1:0] curAddrFlat,
  output logic [CH_NUM*WORD_W-1:0] curCountFlat,
  output logic [CH_NUM*WORD_W-1:0] baseAddrFlat,
  output logic [CH_NUM*WORD_W-1:0] baseCountFlat,
  output logic [CH_NUM*MODE_W-1:0] modeFlat,
  output logic [BYTE_W-1:0]        cmdBits,
  output logic [CH_NUM-1:0]        reqBits,
  output logic [CH_NUM-1:0]        maskBits
);
  regStrobes_t strobes;

  dmaRegCtrl ctrl_i (
    .clk      (clk),
    .rstN     (rstN),
    .regAddr  (regAddr),
    .wrStrobe (wrStrobe),
    .rdStrobe (rdStrobe),
    .strobes  (strobes)
  );

  dmaRegData data_i (
    .clk           (clk),
    .rstN          (rstN),
    .strobes       (strobes),
    .wrData        (wrData),
    .dreqRaw       (dreqRaw),
    .tcPulse       (tcPulse),
    .updEn         (updEn),
    .updAddrFlat   (updAddrFlat),
    .updCountFlat  (updCountFlat),
    .rdData        (rdData),
    .curAddrFlat   (curAddrFlat),
    .curCountFlat  (curCountFlat),
    .baseAddrFlat  (baseAddrFlat),
    .baseCountFlat (baseCountFlat),
    .modeFlat      (modeFlat),
    .cmdBits       (cmdBits),
    .reqBits       (reqBits),
    .maskBits      (maskBits)
  );
endmodule

// File: rtl/dmaRegChk.sv
module dmaRegChk
  import dmaRegPkg::*;
(
  input logic                     clk,
  input logic                     rstN,
  input logic [OFF_W-1:0]         regAddr,
  input logic [BYTE_W-1:0]        wrData,
  input logic                     wrStrobe,
  input logic                     rdStrobe,
  input logic [BYTE_W-1:0]        rdData,
  input logic [CH_NUM-1:0]        dreqRaw,
  input logic [CH_NUM-1:0]        updEn,
  input logic [CH_NUM*WORD_W-1:0] updAddrFlat,
  input logic [CH_NUM*WORD_W-1:0] curAddrFlat,
  input logic [CH_NUM*MODE_W-1:0] modeFlat,
  input logic [BYTE_W-1:0]        cmdBits,
  input logic [CH_NUM-1:0]        reqBits,
  input logic [CH_NUM-1:0]        maskBits
);
  assert_cmd_load_R5: assert property (@(posedge clk) disable iff (!rstN)
    wrStrobe && regAddr == 4'd8 |=> cmdBits == $past(wrData));

  assert_status_req_nibble_R5: assert property (@(posedge clk) disable iff (!rstN)
    rdStrobe && !wrStrobe && regAddr == 4'd8 |=> rdData[BYTE_W-1:CH_NUM] == $past(dreqRaw));

  assert_mask_none_R8: assert property (@(posedge clk) disable iff (!rstN)
    wrStrobe && regAddr == 4'd14 |=> maskBits == '0);

  assert_mask_all_R8: assert property (@(posedge clk) disable iff (!rstN)
    wrStrobe && regAddr == 4'd15 |=> maskBits == $past(wrData[CH_NUM-1:0]));

  assert_mode_ch0_R9: assert property (@(posedge clk) disable iff (!rstN)
    wrStrobe && regAddr == 4'd11 && wrData[CH_W-1:0] == '0
    |=> modeFlat[MODE_W-1:0] == $past(wrData[BYTE_W-1:CH_W]));

  assert_master_clear_R10: assert property (@(posedge clk) disable iff (!rstN)
    wrStrobe && regAddr == 4'd13 |=> maskBits == '1 && cmdBits == '0 && reqBits == '0);

  assert_seq_update_R11: assert property (@(posedge clk) disable iff (!rstN)
    updEn[0] && !wrStrobe |=> curAddrFlat[WORD_W-1:0] == $past(updAddrFlat[WORD_W-1:0]));

  assert_unused_read_zero_R12: assert property (@(posedge clk) disable iff (!rstN)
    rdStrobe && !wrStrobe && regAddr > 4'd8 |=> rdData == '0);
endmodule

bind dmaRegFile dmaRegChk chk_i (.*);

// File: tb/dmaRegFile_tb_top.sv
`timescale 1ns/1ps
module dmaRegFile_tb_top;
  import dmaRegPkg::*;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic [3:0]  regAddr = '0;
  logic [7:0]  wrData = '0;
  logic        wrStrobe = 1'b0, rdStrobe = 1'b0;
  logic [3:0]  dreqRaw = '0, tcPulse = '0, updEn = '0;
  logic [63:0] updAddrFlat = '0, updCountFlat = '0;
  logic [7:0]  rdData;
  logic [63:0] curAddrFlat, curCountFlat, baseAddrFlat, baseCountFlat;
  logic [23:0] modeFlat;
  logic [7:0]  cmdBits;
  logic [3:0]  reqBits, maskBits;

  always #2 clk = ~clk;

  dmaRegFile dut_i (.*);

  // behavioural reference state
  logic [15:0] mBaseA [4], mCurA [4], mBaseC [4], mCurC [4];
  logic [5:0]  mMode [4];
  logic [7:0]  mCmd, mRd;
  logic [3:0]  mReq, mMask, mTc;
  logic        mPtr;
  logic [15:0] mWord;
  logic        mStatClr;
  int          mCh;

  int vectors = 0;
  int miscompares = 0;
  int cycles = 0;
  bit finished = 0;
  string curReq = "R1";

  always @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      for (int i = 0; i < 4; i++) begin
        mBaseA[i] = 0; mCurA[i] = 0; mBaseC[i] = 0; mCurC[i] = 0; mMode[i] = 0;
      end
      mCmd = 0; mRd = 0; mReq = 0; mMask = 4'hF; mTc = 0; mPtr = 0;
    end else begin
      mStatClr = 0;
      if (rdStrobe && !wrStrobe) begin
        if (regAddr < 8) begin
          mCh = int'(regAddr[2:1]);
          mWord = regAddr[0] ? mCurC[mCh] : mCurA[mCh];
          mRd = mPtr ? mWord[15:8] : mWord[7:0];
          mPtr = !mPtr;
        end else if (regAddr == 8) begin
          mRd = {dreqRaw, mTc};
          mStatClr = 1;
        end else begin
          mRd = 8'h00;
        end
      end
      for (int i = 0; i < 4; i++) begin
        if (updEn[i]) begin
          mCurA[i] = updAddrFlat[i*16 +: 16];
          mCurC[i] = updCountFlat[i*16 +: 16];
        end
      end
      mTc = (mStatClr ? 4'h0 : mTc) | tcPulse;
      if (wrStrobe) begin
        if (regAddr < 8) begin
          mCh = int'(regAddr[2:1]);
          if (regAddr[0]) begin
            if (mPtr) begin mBaseC[mCh][15:8] = wrData; mCurC[mCh][15:8] = wrData; end
            else begin mBaseC[mCh][7:0] = wrData; mCurC[mCh][7:0] = wrData; end
          end else begin
            if (mPtr) begin mBaseA[mCh][15:8] = wrData; mCurA[mCh][15:8] = wrData; end
            else begin mBaseA[mCh][7:0] = wrData; mCurA[mCh][7:0] = wrData; end
          end
          mPtr = !mPtr;
        end else begin
          case (regAddr)
            4'd8:  mCmd = wrData;
            4'd9:  mReq[wrData[1:0]] = wrData[2];
            4'd10: mMask[wrData[1:0]] = wrData[2];
            4'd11: mMode[wrData[1:0]] = wrData[7:2];
            4'd12: mPtr = 0;
            4'd13: begin mCmd = 0; mTc = 0; mReq = 0; mPtr = 0; mMask = 4'hF; end
            4'd14: mMask = 0;
            default: mMask = wrData[3:0];
          endcase
        end
      end
    end
  end

  task automatic cmpField(string tag, logic [63:0] got, logic [63:0] exp);
    if (got !== exp) begin
      miscompares++;
      $display("FAIL %s (phase %s) actual %h expected %h", tag, curReq, got, exp);
    end
  endtask

  always @(negedge clk) begin
    if (!finished) begin
      vectors++;
      cmpField("R3 R5 R12 rdData", 64'(rdData), 64'(mRd));
      cmpField("R5 R10 cmdBits", 64'(cmdBits), 64'(mCmd));
      cmpField("R7 R10 reqBits", 64'(reqBits), 64'(mReq));
      cmpField("R8 R10 maskBits", 64'(maskBits), 64'(mMask));
      for (int i = 0; i < 4; i++) begin
        cmpField("R2 R11 curAddr", 64'(curAddrFlat[i*16 +: 16]), 64'(mCurA[i]));
        cmpField("R2 R11 curCount", 64'(curCountFlat[i*16 +: 16]), 64'(mCurC[i]));
        cmpField("R2 baseAddr", 64'(baseAddrFlat[i*16 +: 16]), 64'(mBaseA[i]));
        cmpField("R2 baseCount", 64'(baseCountFlat[i*16 +: 16]), 64'(mBaseC[i]));
        cmpField("R9 mode", 64'(modeFlat[i*6 +: 6]), 64'(mMode[i]));
      end
    end
  end

  task automatic drive(input logic [3:0] a, input logic [7:0] d, input logic w, input logic r);
    @(negedge clk); #1;
    regAddr = a; wrData = d; wrStrobe = w; rdStrobe = r;
    tcPulse = 0; updEn = 0;
  endtask

  task automatic wr(input logic [3:0] a, input logic [7:0] d);
    drive(a, d, 1'b1, 1'b0);
  endtask

  task automatic rd(input logic [3:0] a);
    drive(a, 8'h00, 1'b0, 1'b1);
  endtask

  task automatic idle();
    drive(4'h0, 8'h00, 1'b0, 1'b0);
  endtask

  task automatic expectRd(string req, logic [7:0] exp);
    @(negedge clk);
    vectors++;
    if (rdData !== exp) begin
      miscompares++;
      $display("FAIL %s read data actual %h expected %h", req, rdData, exp);
    end
  endtask

  task automatic summary();
    if (!finished) begin
      finished = 1;
      $display("  == %0d vectors applied, %0d miscompares ==", vectors, miscompares);
      $finish;
    end
  endtask

  always @(posedge clk) begin
    cycles++;
    if (cycles > 100000 && !finished) begin
      miscompares++;
      $display("FAIL watchdog expired (phase %s) actual %0d expected below 100000", curReq, cycles);
      summary();
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    // R1: reset state
    vectors++;
    if (maskBits !== 4'hF || cmdBits !== 8'h00 || reqBits !== 4'h0 || rdData !== 8'h00
        || curAddrFlat !== '0 || modeFlat !== '0) begin
      miscompares++;
      $display("FAIL R1 reset state actual mask %h cmd %h expected mask f cmd 00", maskBits, cmdBits);
    end
    #1 rstN = 1'b1;

    curReq = "R2";
    wr(4'd0, 8'h34); wr(4'd0, 8'h12);
    wr(4'd7, 8'hCD); wr(4'd7, 8'hAB);
    idle();

    curReq = "R3";
    rd(4'd0); idle(); expectRd("R3", 8'h34);
    rd(4'd0); idle(); expectRd("R3", 8'h12);

    curReq = "R4";
    wr(4'd2, 8'hAA); wr(4'd12, 8'hFF); wr(4'd2, 8'hBB); wr(4'd2, 8'h77);
    idle();

    curReq = "R6";
    idle(); tcPulse = 4'b0101; dreqRaw = 4'b1001;
    idle();
    curReq = "R5";
    wr(4'd8, 8'h5A);
    rd(4'd8); idle(); expectRd("R5", 8'h95);
    rd(4'd8); tcPulse = 4'b0010; idle(); expectRd("R5", 8'h90);
    rd(4'd8); idle(); expectRd("R6", 8'h92);

    curReq = "R7";
    wr(4'd9, 8'h06); wr(4'd9, 8'h07); wr(4'd9, 8'h02);
    curReq = "R8";
    wr(4'd10, 8'h01); wr(4'd14, 8'h00); wr(4'd10, 8'h07); wr(4'd15, 8'hA6); wr(4'd10, 8'h02);
    curReq = "R9";
    wr(4'd11, 8'hFC); wr(4'd11, 8'h4A); wr(4'd11, 8'h01);
    curReq = "R10";
    wr(4'd0, 8'h11); wr(4'd13, 8'h00); idle();
    wr(4'd0, 8'h22); idle();

    curReq = "R11";
    idle(); updEn = 4'b0011; updAddrFlat = 64'h0000_0000_BEEF_CAFE; updCountFlat = 64'h0000_0000_0102_0304;
    wr(4'd0, 8'h55); updEn = 4'b0001; updAddrFlat = 64'h0000_0000_0000_9876;
    idle();

    curReq = "R12";
    for (int a = 9; a < 16; a++) begin rd(4'(a)); idle(); expectRd("R12", 8'h00); end
    drive(4'd8, 8'h3C, 1'b1, 1'b1); idle();
    rd(4'd1); idle();

    curReq = "random";
    for (int n = 0; n < 6000; n++) begin
      int p;
      p = int'($urandom_range(0, 9));
      @(negedge clk); #1;
      regAddr  = 4'($urandom);
      wrData   = 8'($urandom);
      wrStrobe = (p < 3);
      rdStrobe = (p >= 2 && p < 6);
      if (wrStrobe && regAddr == 4'd13 && $urandom_range(0, 3) != 0) wrStrobe = 1'b0;
      tcPulse  = ($urandom_range(0, 7) == 0) ? 4'($urandom) : 4'h0;
      updEn    = ($urandom_range(0, 5) == 0) ? 4'($urandom) : 4'h0;
      updAddrFlat  = {$urandom, $urandom};
      updCountFlat = {$urandom, $urandom};
      dreqRaw  = 4'($urandom);
    end
    idle(); idle();
    @(negedge clk);
    summary();
  end
endmodule